// File: doc/BRIEF.md
# Paged Monochrome Display Buffer Controller

This block holds the picture for a 128 by 64 dot display that has one bit per dot. Software programs it with 32-bit register accesses. The picture is kept as eight horizontal bands of eight rows each, called pages. Each page holds 128 bytes, one for each column. Bit n of a column byte is row n of that band.

A mode register decides what a write to the data port means. In command mode, the byte selects a page. In data mode, the byte is stored at the current page and column, and the column then moves on by one. A scan-out engine reads single dots through a separate port that takes a column and a row. Three brightness lines set a 3-bit level, and the block scales an 8-bit colour value by that level. One further register is plain read/write storage that a driver may use for interrupt settings.

Top module: `mono_lcd_fb`

## Requirements
- R1: Register offsets are: interrupt-control storage at 0x180, mode at 0x1AC, page instruction at 0x1BC and data port at 0x1C0. An access takes effect only if all four byte enables are set. A write with fewer byte enables changes nothing, and a read with fewer byte enables returns zero.
- R2: A write of 0x00100011 to the mode register selects data mode, and a write of 0x00104011 selects command mode. Any other written value selects the invalid mode (code 0).
- R3: A write to the instruction register of a value from 0xB0 to 0xB7 sets the page to (value − 0xB0) and the column to 0. Any other value leaves the page and the column unchanged.
- R4: In command mode, a data-port write of a value from 0xB0 to 0xB7 selects a page exactly as R3 does. Other values leave the page, the column and the memory unchanged.
- R5: In data mode, a data-port write stores bits 7:0 at byte address page·128 + column. The column then advances modulo 128 and the page stays the same.
- R6: In the invalid mode, data-port writes change neither the memory nor the column.
- R7: A dot read with pix_rd high returns, on pix_bit after the next clock edge, bit (y mod 8) of the byte at address x + (y/8)·128. pix_bit holds its value while pix_rd is low.
- R8: The brightness lines are registered, one line per bit. The output is level_out = color_in·b/7 with the quotient rounded down. This gives the full colour at b = 7 and zero at b = 0. The output never exceeds color_in.
- R9: A read returns, one cycle later on bus_rdata, the last value written to the interrupt-control register. A read of any other offset returns zero.
- R10: Reset sets the mode to invalid, the page and the column to 0, the interrupt-control storage to 0 and the brightness to 7. The memory contents are not defined after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pix_rd | input | 1 | Dot read request |
| pix_x | input | 7 | Dot column 0..127 |
| pix_y | input | 6 | Dot row 0..63 |
| pix_bit | output | 1 | Dot value, one cycle after the request |
| bright_in | input | 3 | Brightness lines, one per bit |
| color_in | input | 8 | Colour intensity to scale |
| level_out | output | 8 | Scaled intensity |

## Verification
The assertions assume that every register access lasts a single cycle with its address, data and byte enables held stable. They also assume that the dot port never reads a byte that has not been written since reset, because the memory comes up undefined. The bench drives all inputs on the falling edge and raises bus_sel for exactly one cycle per access. Before it reads any dot, it writes the byte that holds that dot. Brightness codes and colour values come from a fixed table, so the scaling product always stays within its 11-bit range.

// File: rtl/mono_lcd_pkg.sv
package mono_lcd_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DATA = 2'd1,
        MODE_CMD  = 2'd2
    } lcd_mode_e;

    localparam logic [31:0] KEY_DATA = 32'h0010_0011;
    localparam logic [31:0] KEY_CMD  = 32'h0010_4011;

    localparam logic [11:0] OFF_IRQ   = 12'h180;
    localparam logic [11:0] OFF_MODE  = 12'h1AC;
    localparam logic [11:0] OFF_INSTR = 12'h1BC;
    localparam logic [11:0] OFF_DATA  = 12'h1C0;

    localparam logic [31:0] PAGE_CODE_LO = 32'h0000_00B0;
endpackage

// File: rtl/lcd_reg_front.sv
module lcd_reg_front
    import mono_lcd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12,
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_sel,
    input  logic                    acc_wr,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [DATA_W/8-1:0]     acc_be,
    input  logic [DATA_W-1:0]       acc_wdata,
    output logic [DATA_W-1:0]       rdata,
    output logic                    vram_we,
    output logic [PAGE_W+COL_W-1:0] vram_waddr,
    output logic [7:0]              vram_wdata
);
    localparam int PAGES = 1 << PAGE_W;
    localparam logic [DATA_W-1:0] PG_LO = DATA_W'(PAGE_CODE_LO);
    localparam logic [DATA_W-1:0] PG_HI = PG_LO + DATA_W'(PAGES - 1);

    typedef struct packed {
        lcd_mode_e          mode;
        logic [PAGE_W-1:0]  page;
        logic [COL_W-1:0]   col;
        logic [DATA_W-1:0]  irqctl;
        logic [DATA_W-1:0]  rdata;
    } front_t;

    front_t q, d;
    logic full, wr_ok, rd_ok, page_code;
    logic [DATA_W-1:0] code_off;

    always_comb begin
        full      = acc_sel && (acc_be == '1);
        wr_ok     = full && acc_wr;
        rd_ok     = full && !acc_wr;
        page_code = (acc_wdata >= PG_LO) && (acc_wdata <= PG_HI);
        code_off  = acc_wdata - PG_LO;
        d          = q;
        vram_we    = 1'b0;
        vram_waddr = {q.page, q.col};
        vram_wdata = acc_wdata[7:0];

        if (acc_sel && !acc_wr && !full) begin
            d.rdata = '0;
        end
        if (rd_ok) begin
            d.rdata = (acc_addr == ADDR_W'(OFF_IRQ)) ? q.irqctl : '0;
        end
        if (wr_ok) begin
            if (acc_addr == ADDR_W'(OFF_IRQ)) begin
                d.irqctl = acc_wdata;
            end else if (acc_addr == ADDR_W'(OFF_MODE)) begin
                if (acc_wdata == DATA_W'(KEY_DATA))     d.mode = MODE_DATA;
                else if (acc_wdata == DATA_W'(KEY_CMD)) d.mode = MODE_CMD;
                else                                    d.mode = MODE_OFF;
            end else if (acc_addr == ADDR_W'(OFF_INSTR)) begin
                if (page_code) begin
                    d.page = code_off[PAGE_W-1:0];
                    d.col  = '0;
                end
            end else if (acc_addr == ADDR_W'(OFF_DATA)) begin
                if (q.mode == MODE_CMD && page_code) begin
                    d.page = code_off[PAGE_W-1:0];
                    d.col  = '0;
                end else if (q.mode == MODE_DATA) begin
                    vram_we = 1'b1;
                    d.col   = q.col + COL_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.mode   <= MODE_OFF;
            q.page   <= '0;
            q.col    <= '0;
            q.irqctl <= '0;
            q.rdata  <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;

    // Mode register: unrecognised keys fall back to the invalid mode
    assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && acc_addr == ADDR_W'(OFF_MODE) &&
         acc_wdata != DATA_W'(KEY_DATA) && acc_wdata != DATA_W'(KEY_CMD))
        |=> (q.mode == MODE_OFF));

    // Instruction register page select
    assert_page_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && acc_addr == ADDR_W'(OFF_INSTR) && acc_wdata[DATA_W-1:4] == PG_LO[DATA_W-1:4]
         && acc_wdata[3] == 1'b0)
        |=> (q.col == '0 && q.page == $past(acc_wdata[PAGE_W-1:0])));

    // Each stored byte moves the column by one, modulo the row length
    assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |=> (q.col == $past(q.col) + COL_W'(1)) && $stable(q.page));

    // No memory write unless data mode is active
    assert_no_write_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode != MODE_DATA) |-> !vram_we);
endmodule

// File: rtl/lcd_vram.sv
module lcd_vram #(
    parameter int COL_W  = 7,
    parameter int PAGE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [PAGE_W+COL_W-1:0] waddr,
    input  logic [7:0]              wdata,
    input  logic                    rd_en,
    input  logic [COL_W-1:0]        rd_x,
    input  logic [PAGE_W+2:0]       rd_y,
    output logic                    rd_bit
);
    localparam int DEPTH = 1 << (PAGE_W + COL_W);

    logic [7:0] mem [DEPTH];
    logic       bit_d, bit_q;
    logic [PAGE_W+COL_W-1:0] raddr;

    always_comb begin
        raddr = {rd_y[PAGE_W+2:3], rd_x};
        bit_d = rd_en ? mem[raddr][rd_y[2:0]] : bit_q;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
    end

    assign rd_bit = bit_q;

    // Output holds when no read is requested
    assert_hold_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_bit));
endmodule

// File: rtl/lcd_intensity.sv
module lcd_intensity #(
    parameter int BRIGHT_W = 3,
    parameter int COLOR_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BRIGHT_W-1:0] bright_in,
    input  logic [COLOR_W-1:0]  color_in,
    output logic [COLOR_W-1:0]  level_out
);
    localparam int PROD_W = COLOR_W + BRIGHT_W;
    localparam logic [BRIGHT_W-1:0] B_MAX = '1;

    logic [BRIGHT_W-1:0] bright_d, bright_q;
    logic [PROD_W-1:0]   prod, quot;

    always_comb begin
        bright_d = bright_in;
        prod     = PROD_W'(color_in) * PROD_W'(bright_q);
        quot     = prod / PROD_W'(B_MAX);
        if (bright_q == B_MAX)      level_out = color_in;
        else if (bright_q == '0)    level_out = '0;
        else                        level_out = quot[COLOR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bright_q <= B_MAX;
        else        bright_q <= bright_d;
    end

    // Scaling never brightens
    assert_no_boost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        level_out <= color_in);
endmodule

// File: rtl/mono_lcd_fb.sv
module mono_lcd_fb #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 12,
    parameter int COL_W    = 7,
    parameter int PAGE_W   = 3,
    parameter int BRIGHT_W = 3,
    parameter int COLOR_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                pix_rd,
    input  logic [COL_W-1:0]    pix_x,
    input  logic [PAGE_W+2:0]   pix_y,
    output logic                pix_bit,
    input  logic [BRIGHT_W-1:0] bright_in,
    input  logic [COLOR_W-1:0]  color_in,
    output logic [COLOR_W-1:0]  level_out
);
    localparam int VA_W = PAGE_W + COL_W;

    logic            vram_we;
    logic [VA_W-1:0] vram_waddr;
    logic [7:0]      vram_wdata;

    lcd_reg_front #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .PAGE_W(PAGE_W)
    ) u_front (
        .clk(clk), .rst_n(rst_n),
        .acc_sel(bus_sel), .acc_wr(bus_wr), .acc_addr(bus_addr),
        .acc_be(bus_be), .acc_wdata(bus_wdata), .rdata(bus_rdata),
        .vram_we(vram_we), .vram_waddr(vram_waddr), .vram_wdata(vram_wdata)
    );

    lcd_vram #(.COL_W(COL_W), .PAGE_W(PAGE_W)) u_vram (
        .clk(clk), .rst_n(rst_n),
        .we(vram_we), .waddr(vram_waddr), .wdata(vram_wdata),
        .rd_en(pix_rd), .rd_x(pix_x), .rd_y(pix_y), .rd_bit(pix_bit)
    );

    lcd_intensity #(.BRIGHT_W(BRIGHT_W), .COLOR_W(COLOR_W)) u_level (
        .clk(clk), .rst_n(rst_n),
        .bright_in(bright_in), .color_in(color_in), .level_out(level_out)
    );
endmodule

// File: tb/mono_lcd_fb_test.sv
module mono_lcd_fb_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // {brightness[2:0], colour[7:0], expected level[7:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {3'd7, 8'hE0, 8'hE0}, {3'd0, 8'hFF, 8'h00},
        {3'd3, 8'hE0, 8'h60}, {3'd5, 8'hFF, 8'hB6},
        {3'd1, 8'hFF, 8'h24}, {3'd6, 8'h80, 8'h6D},
        {3'd2, 8'h0F, 8'h04}, {3'd4, 8'hE0, 8'h80}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, pix_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [6:0]  pix_x = '0;
    logic [5:0]  pix_y = '0;
    logic        pix_bit;
    logic [2:0]  bright_in = 3'd0;
    logic [7:0]  color_in = 8'hC8, level_out;
    int n_cmp = 0, n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mono_lcd_fb uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pix_rd(pix_rd), .pix_x(pix_x), .pix_y(pix_y),
        .pix_bit(pix_bit), .bright_in(bright_in), .color_in(color_in),
        .level_out(level_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v, input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp,
                            input logic [3:0] be = 4'hF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_be = '0;
        check(req, bus_rdata, exp);
    endtask

    task automatic pix_check(input string req, input int x, input int y, input logic exp);
        @(negedge clk);
        pix_rd = 1'b1; pix_x = 7'(x); pix_y = 6'(y);
        @(negedge clk);
        pix_rd = 1'b0;
        check(req, {31'd0, pix_bit}, {31'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R10: brightness held at 7 in reset although lines read 0
        #(CLK_PERIOD * 3);
        check("R10 brightness reset", {24'd0, level_out}, 32'h0000_00C8);
        @(negedge clk); rst_n = 1'b1;
        rd_check("R10 irq reset", 12'h180, 32'h0);

        // R8: table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bright_in = VEC[i][18:16]; color_in = VEC[i][15:8];
            @(negedge clk);
            check("R8 scaling", {24'd0, level_out}, {24'd0, VEC[i][7:0]});
        end
        bright_in = 3'd7;

        // R9 / R1
        wr(12'h180, 32'hDEAD_BEEF);
        rd_check("R9 irq readback", 12'h180, 32'hDEAD_BEEF);
        rd_check("R9 other offset reads zero", 12'h1AC, 32'h0);
        wr(12'h180, 32'h1234_5678, 4'h3);
        rd_check("R1 partial write ignored", 12'h180, 32'hDEAD_BEEF);
        rd_check("R1 partial read zero", 12'h180, 32'h0, 4'h1);

        // R2 / R3 / R5: data mode, page 2
        wr(12'h1AC, 32'h0010_0011);
        wr(12'h1BC, 32'hB2);
        wr(12'h1C0, 32'hA5);
        wr(12'h1C0, 32'h3C);
        pix_check("R5 byte0 bit0", 0, 16, 1'b1);
        pix_check("R7 byte0 bit1", 0, 17, 1'b0);
        pix_check("R7 byte1 bit2", 1, 18, 1'b1);
        wr(12'h1BC, 32'hB8);          // R3: not a page code
        wr(12'h1BC, 32'h1B2);         // R3: wider value, ignored
        wr(12'h1C0, 32'h01);
        pix_check("R3 ignored code keeps page/col", 2, 16, 1'b1);

        // R4: command mode via data port
        wr(12'h1AC, 32'h0010_4011);
        wr(12'h1C0, 32'hB5);
        wr(12'h1C0, 32'hFF);          // not a page code
        wr(12'h1AC, 32'h0010_0011);
        wr(12'h1C0, 32'h81);
        pix_check("R4 page5 bit0", 0, 40, 1'b1);
        pix_check("R4 page5 bit7", 0, 47, 1'b1);
        pix_check("R4 page5 bit1", 0, 41, 1'b0);

        // R5 wrap on page 7, page 6 untouched
        wr(12'h1BC, 32'hB6);
        wr(12'h1C0, 32'h00);
        wr(12'h1BC, 32'hB7);
        for (int c = 0; c < 128; c++) wr(12'h1C0, 32'h00);
        wr(12'h1C0, 32'hFF);
        pix_check("R5 wrap to col0", 0, 56, 1'b1);
        pix_check("R5 col1 still zero", 1, 56, 1'b0);
        pix_check("R5 page6 untouched", 0, 55, 1'b0);

        // R2 / R6: bad key gives invalid mode
        wr(12'h1AC, 32'h1234_5678);
        wr(12'h1C0, 32'hFF);
        pix_check("R6 no store in invalid mode", 1, 56, 1'b0);
        wr(12'h1AC, 32'h0010_0011);
        wr(12'h1C0, 32'h02);
        pix_check("R6 column did not advance", 1, 57, 1'b1);
        pix_check("R2 data mode restored", 1, 56, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule